// File: doc/BRIEF.md
# Pseudo-Random Noise Waveform Register

This block holds a 23-bit linear feedback shift register that produces the noise waveform of a sound oscillator. An oscillator-side pipeline supplies a one-cycle strobe each time the register should advance. On each strobe the register moves one place towards its top bit, and a new bit 0 is formed from two feedback taps. A test input is ORed into that feedback. Eight scattered register bits are gathered into the top byte of a 12-bit waveform word. The low nibble of that word is tied to zero.

Two secondary paths change the register without a strobe. The first is a write-back port. A mixed waveform that includes noise returns its 12-bit result on this port, and any tapped bit whose matching result bit is zero is cleared. The second is a reset timer. When the test input stays high for a programmable number of clock edges, the register returns to all ones. The waveform word is read straight from the register, so it changes on the same edge as the register.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While `rst_ni` is low the register is all ones and the timer is reloaded, so after reset `noise_o` reads 12'hFF0.
- R2: On an edge with `noise_clk_i` high, the register shifts left by one and bit 0 takes bit 22 XOR bit 17. On an edge with no strobe, no write-back and no timer expiry, the register holds its value.
- R3: The feedback bit is ORed with `test_i`, so a shift taken while test is high always puts a 1 into bit 0.
- R4: `noise_o[11:4]` carry register bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order from bit 11 down to bit 4. `noise_o[3:0]` is always zero.
- R5: A counter is loaded with RESET_CYCLES whenever `test_i` is low, and counts down on each edge with `test_i` high. On the edge where it moves from 1 to 0, the register becomes all ones. A low test input restarts the count from the full value.
- R6: On an edge with `wb_en_i` high, the register bit that drives `noise_o[k]` (for k from 4 to 11) is ANDed with `wb_data_i[k]`. Untapped bits are unchanged, `wb_data_i[3:0]` has no effect, and a write-back never sets a bit.
- R7: When several actions fall on the same edge, the write-back is applied first and the shift is taken from the cleared value. A timer expiry overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| noise_clk_i | input | 1 | One-cycle shift strobe from the oscillator |
| test_i | input | 1 | Test level: forces feedback high and drives the reset timer |
| wb_en_i | input | 1 | Write-back enable from the mixed-waveform path |
| wb_data_i | input | 12 | Mixed waveform result to write back |
| noise_o | output | 12 | Noise waveform word |

## Verification
The assertions assume that `noise_clk_i` is a clean one-cycle level sampled at each edge. They also assume that write-back, strobe and test may all change together in any cycle, with no handshake between them. The stimulus drives every input on the falling edge. It mixes regular and irregular strobe spacing with write-back and test pulses, and it includes edges where all three actions coincide with a timer expiry. Test is held both for less than the countdown and for longer than it, so that the restart behaviour is covered as well as the expiry itself.

// File: rtl/noise_pkg.sv
package noise_pkg;
    localparam int unsigned LFSR_BITS = 23;
    localparam int unsigned FB_HI     = 22;
    localparam int unsigned FB_LO     = 17;
    localparam int unsigned OUT_BITS  = 12;
    localparam int unsigned TAP_COUNT = 8;
    // entry i drives waveform bit OUT_BITS-1-i
    localparam int unsigned TAP_POS [TAP_COUNT] = '{22, 20, 16, 13, 11, 7, 4, 2};

    typedef logic [LFSR_BITS-1:0] lfsr_t;
    typedef logic [OUT_BITS-1:0]  wave_t;

    typedef struct packed {
        lfsr_t lfsr;
    } core_st_t;
endpackage

// File: rtl/noise_reset_timer.sv
module noise_reset_timer #(
    parameter int unsigned RESET_CYCLES = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic test_i,
    output logic expire_o
);
    localparam int unsigned CNT_W = $clog2(RESET_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RESET_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (!test_i) begin
            st_d.cnt = CNT_FULL;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            expire_d = (st_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt <= CNT_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = expire_d;

    // R5
    single_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);
endmodule

// File: rtl/noise_tap_map.sv
module noise_tap_map
    import noise_pkg::*;
(
    input  lfsr_t lfsr_i,
    input  wave_t wb_data_i,
    output wave_t wave_o,
    output lfsr_t keep_mask_o
);
    localparam int unsigned GND_BITS = OUT_BITS - TAP_COUNT;

    for (genvar i = 0; i < TAP_COUNT; i++) begin : g_tap
        assign wave_o[OUT_BITS-1-i] = lfsr_i[TAP_POS[i]];
    end
    assign wave_o[GND_BITS-1:0] = '0;

    always_comb begin
        keep_mask_o = '1;
        for (int i = 0; i < TAP_COUNT; i++) begin
            keep_mask_o[TAP_POS[i]] = wb_data_i[OUT_BITS-1-i];
        end
    end
endmodule

// File: rtl/noise_lfsr_core.sv
module noise_lfsr_core
    import noise_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  shift_i,
    input  logic  test_i,
    input  logic  wb_en_i,
    input  lfsr_t keep_mask_i,
    input  logic  expire_i,
    output lfsr_t lfsr_o
);
    core_st_t st_d, st_q;
    lfsr_t    cleared;
    logic     fb;

    always_comb begin
        st_d    = st_q;
        cleared = wb_en_i ? (st_q.lfsr & keep_mask_i) : st_q.lfsr;
        fb      = (cleared[FB_HI] ^ cleared[FB_LO]) | test_i;
        st_d.lfsr = cleared;
        if (shift_i) begin
            st_d.lfsr = {cleared[LFSR_BITS-2:0], fb};
        end
        if (expire_i) begin
            st_d.lfsr = '1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.lfsr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lfsr_o = st_q.lfsr;

    // R3
    test_sets_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && test_i && !expire_i) |=> lfsr_o[0]);

    // R2
    shift_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !wb_en_i && !expire_i) |=> lfsr_o[LFSR_BITS-1:1] == $past(lfsr_o[LFSR_BITS-2:0]));
endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
    import noise_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = 4096
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        noise_clk_i,
    input  logic        test_i,
    input  logic        wb_en_i,
    input  logic [11:0] wb_data_i,
    output logic [11:0] noise_o
);
    lfsr_t lfsr;
    lfsr_t keep_mask;
    logic  expire;

    noise_reset_timer #(
        .RESET_CYCLES(RESET_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .test_i  (test_i),
        .expire_o(expire)
    );

    noise_tap_map u_map (
        .lfsr_i     (lfsr),
        .wb_data_i  (wb_data_i),
        .wave_o     (noise_o),
        .keep_mask_o(keep_mask)
    );

    noise_lfsr_core u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_i    (noise_clk_i),
        .test_i     (test_i),
        .wb_en_i    (wb_en_i),
        .keep_mask_i(keep_mask),
        .expire_i   (expire),
        .lfsr_o     (lfsr)
    );

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!noise_clk_i && !wb_en_i && !expire) |=> $stable(noise_o));

    // R6
    wb_never_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_en_i && !noise_clk_i && !expire) |=> ((noise_o & ~$past(noise_o)) == 12'h000));

    // R5
    expire_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> (noise_o == 12'hFF0));
endmodule

// File: tb/noise_lfsr_gen_tb.sv
`timescale 1ns/1ps
module noise_lfsr_gen_tb;
    localparam int unsigned NCYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        test = 1'b0;
    logic        wb_en = 1'b0;
    logic [11:0] wb_data = '0;
    logic [11:0] noise;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [22:0] m_reg = '1;
    int unsigned m_cnt = NCYC;

    logic [11:0] q_exp [$];
    string       q_tag [$];

    always #2.5 clk = ~clk;

    noise_lfsr_gen #(.RESET_CYCLES(NCYC)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .noise_clk_i(strobe),
        .test_i     (test),
        .wb_en_i    (wb_en),
        .wb_data_i  (wb_data),
        .noise_o    (noise)
    );

    function automatic logic [11:0] view(input logic [22:0] r);
        return {r[22], r[20], r[16], r[13], r[11], r[7], r[4], r[2], 4'b0000};
    endfunction

    task automatic compare(input logic [11:0] got, input logic [11:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: noise_o=%h expected=%h", tag, got, exp);
        end
    endtask

    // driver: applies one edge of stimulus and queues the expected word
    task automatic step(input bit s, input bit t, input bit w, input logic [11:0] d, input string tag);
        logic [22:0] v;
        bit          ex;
        @(negedge clk);
        strobe = s; test = t; wb_en = w; wb_data = d;
        v = m_reg;
        if (w) begin
            v[22] &= d[11]; v[20] &= d[10]; v[16] &= d[9]; v[13] &= d[8];
            v[11] &= d[7];  v[7]  &= d[6];  v[4]  &= d[5]; v[2]  &= d[4];
        end
        if (s) v = {v[21:0], (v[22] ^ v[17]) | t};
        ex = 1'b0;
        if (!t) m_cnt = NCYC;
        else if (m_cnt != 0) begin
            if (m_cnt == 1) ex = 1'b1;
            m_cnt--;
        end
        if (ex) v = '1;
        m_reg = v;
        q_exp.push_back(view(v));
        q_tag.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() != 0) compare(noise, q_exp.pop_front(), q_tag.pop_front());
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, got=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        compare(noise, 12'hFF0, "R1 reset state");
        // R2/R4: regular strobe spacing
        for (int i = 0; i < 150; i++) step(i % 3 == 0, 0, 0, '0, "R2 R4 regular");
        // R2: irregular strobes
        for (int i = 0; i < 200; i++) step($urandom_range(0, 1), 0, 0, '0, "R2 irregular");
        // R3: test high shorter than countdown, strobes each cycle
        for (int i = 0; i < 6; i++) step(1, 1, 0, '0, "R3 test feedback");
        for (int i = 0; i < 30; i++) step(i % 2 == 0, 0, 0, '0, "R2 after test");
        // R6: write-back patterns, low nibble varied
        step(0, 0, 1, 12'hA5F, "R6 wb clear");
        step(0, 0, 1, 12'hFF0, "R6 wb ones no set");
        step(0, 0, 1, 12'h00F, "R6 wb low nibble ignored");
        for (int i = 0; i < 40; i++) step(1, 0, 0, '0, "R2 refill");
        for (int i = 0; i < 60; i++)
            step($urandom_range(0, 1), 0, $urandom_range(0, 1), 12'($urandom), "R7 wb with shift");
        // R5: countdown interrupted then restarted
        for (int i = 0; i < 10; i++) step(0, 1, 0, '0, "R5 partial count");
        step(0, 0, 1, 12'h000, "R6 clear all taps");
        for (int i = 0; i < 15; i++) step(0, 1, 0, '0, "R5 restarted count");
        for (int i = 0; i < 8; i++) step(0, 1, 0, '0, "R5 expiry to ones");
        // R7: expiry coincides with write-back and strobe
        step(0, 0, 1, 12'h000, "R6 clear before expiry");
        for (int i = 0; i < 19; i++) step(0, 1, 0, '0, "R5 count");
        step(1, 1, 1, 12'h000, "R7 expiry overrides");
        step(0, 1, 1, 12'h000, "R5 no second fire");
        for (int i = 0; i < 100; i++)
            step($urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0,
                 12'($urandom), "R7 mixed");
        step(0, 0, 0, '0, "R2 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule